// File: doc/BRIEF.md
# Maskable Sticky Interrupt Controller

This block collects single-bit condition signals from the subsystems of a mixed-signal audio device and turns them into one active-high interrupt request. The inputs are three sample-rate-converter lock indicators, a dynamics-processor over-threshold flag, a PLL lock indicator, the headphone jack-detect pin, four analog fault flags, and an internal strobe that fires when the headphone configuration register is written. Each asynchronous input passes through a two-flop synchronizer. An edge detector then turns it into a one-cycle event pulse. Loss of lock is detected on a falling edge. The threshold flag and the combined fault are detected on a rising edge. The jack pin produces an event on either edge.

Every event is latched in a raw register whether or not it is enabled. A per-source enable mask decides which events are latched in the masked status register. Both registers are cleared by writing 1 to a bit. The request is raised while the global enable is set and any masked status bit is 1. Two pin-function registers steer the request to any of four general-purpose outputs. A synchronous register bus carries writes, and reads are combinational from the address.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req` is 0 and `gpio_out` is 0.
- R2: A masked status bit (address 0xE7) can only become 1 while its enable bit in the mask register (address 0xE5, 1 = enabled) is 1.
- R3: A masked status bit stays 1 until the bus writes 1 to that bit at 0xE7. Writing 0 to the bit, or disabling it in the mask, leaves it set.
- R4: The raw register (0xE6) latches every event regardless of the mask. Writing 1 to a raw bit clears it.
- R5: Bits 0, 1 and 2 record a falling edge of lock indicators 0, 1 and 2. A rising edge records nothing. An input change is visible in the registers at most 3 clock cycles later.
- R6: Bit 3 records a rising edge of the dynamics over-threshold flag. Bit 4 records a falling edge of the PLL lock indicator.
- R7: Bit 6 records every change of the jack pin level, whether rising or falling.
- R8: Any bus write to address 0x36 sets bit 5 in the same clock edge. Bits [1:0] of the written data are stored there and read back, and the upper bits read 0.
- R9: Bit 7 records a rising edge of the OR of the four analog fault flags.
- R10: `irq_req` is 1 exactly when bit 0 of the control register (0xE8) is 1 and any masked status bit is 1.
- R11: Output pin p carries `irq_req` when its 4-bit function code equals 0x1, and 0 for any other code. Pin 0 uses 0xE3[3:0], pin 1 uses 0xE3[7:4], pin 2 uses 0xE4[3:0] and pin 3 uses 0xE4[7:4].
- R12: If an event and a write-1-to-clear of the same bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lock | input | 3 | Sample-rate-converter lock indicators (async) |
| dyn_over | input | 1 | Dynamics over-threshold flag (async) |
| pll_lock | input | 1 | PLL lock indicator (async) |
| jack_pin | input | 1 | Jack-detect pin level (async) |
| fault_flags | input | 4 | Analog fault flags (async) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_req | output | 1 | Interrupt request, active high |
| gpio_out | output | 4 | General-purpose outputs carrying the steered request |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a clear of the same bit. The pulse appears only after the synchronizer and the edge register, and a bus write takes a single cycle. The bench first latches the jack bit. It then toggles the pin on a falling clock edge and counts exactly two rising edges before it drives the 0xE7 clear, so that the clear commits on the edge where the pulse is high. Polarity is checked by restoring every lock input after its loss and confirming that the restoring edge adds nothing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NCONV  = 3;
  localparam int NFAULT = 4;
  localparam int NSRC   = 8;
  localparam int AW     = 8;
  localparam int DW     = 8;

  localparam int BIT_PLL   = NCONV + 1;
  localparam int BIT_DYN   = NCONV;
  localparam int BIT_CFG   = NCONV + 2;
  localparam int BIT_JACK  = NCONV + 3;
  localparam int BIT_FAULT = NCONV + 4;

  localparam logic [AW-1:0] A_HPCFG = 8'h36;
  localparam logic [AW-1:0] A_PINA  = 8'hE3;
  localparam logic [AW-1:0] A_PINB  = 8'hE4;
  localparam logic [AW-1:0] A_MASK  = 8'hE5;
  localparam logic [AW-1:0] A_RAW   = 8'hE6;
  localparam logic [AW-1:0] A_STAT  = 8'hE7;
  localparam logic [AW-1:0] A_CTRL  = 8'hE8;

  localparam logic [3:0] PIN_FN_IRQ = 4'h1;

  function automatic logic went_low(input logic prev, input logic now);
    return prev & ~now;
  endfunction

  function automatic logic went_high(input logic prev, input logic now);
    return ~prev & now;
  endfunction

  function automatic logic toggled(input logic prev, input logic now);
    return prev ^ now;
  endfunction

  function automatic logic [NSRC-1:0] w1c(input logic [NSRC-1:0] cur,
                                          input logic [NSRC-1:0] clr,
                                          input logic [NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irqc_events.sv
module irqc_events
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCONV-1:0]  src_lock,
  input  logic              dyn_over,
  input  logic              pll_lock,
  input  logic              jack_pin,
  input  logic [NFAULT-1:0] fault_flags,
  input  logic              cfg_wr,
  output logic [NSRC-1:0]   ev
);
  localparam int NIN = NCONV + 3 + NFAULT;

  logic [NIN-1:0] async_in, sync_now;
  logic [NCONV+3:0] lvl_now, lvl_prev;

  assign async_in = {fault_flags, jack_pin, pll_lock, dyn_over, src_lock};

  irqc_sync #(.W(NIN)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(sync_now)
  );

  // Level vector after sync: lock[NCONV], dyn, pll, jack, fault-OR
  assign lvl_now = {|sync_now[NIN-1:NCONV+3], sync_now[NCONV+2:0]};

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= '0;
    else     lvl_prev <= lvl_now;
  end

  for (genvar i = 0; i < NCONV; i++) begin : g_lock
    assign ev[i] = went_low(lvl_prev[i], lvl_now[i]);
  end

  assign ev[BIT_DYN]   = went_high(lvl_prev[NCONV], lvl_now[NCONV]);
  assign ev[BIT_PLL]   = went_low(lvl_prev[NCONV+1], lvl_now[NCONV+1]);
  assign ev[BIT_CFG]   = cfg_wr;
  assign ev[BIT_JACK]  = toggled(lvl_prev[NCONV+2], lvl_now[NCONV+2]);
  assign ev[BIT_FAULT] = went_high(lvl_prev[NCONV+3], lvl_now[NCONV+3]);
endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= w1c(q, clr, set);
  end

  // Bits that were set and not cleared remain set
  assert_hold_until_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ((q & $past(q & ~clr)) == $past(q & ~clr)));

  // Same-cycle set and clear: set takes priority
  assert_event_beats_clear_R12: assert property (@(posedge clk) disable iff (rst)
    ((set & clr) != '0) |=> ((q & $past(set & clr)) == $past(set & clr)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCONV-1:0]  src_lock,
  input  logic              dyn_over,
  input  logic              pll_lock,
  input  logic              jack_pin,
  input  logic [NFAULT-1:0] fault_flags,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_req,
  output logic [3:0]        gpio_out
);
  logic [NSRC-1:0] mask_q, ev, raw_q, stat_q, raw_clr, stat_clr;
  logic [1:0]      hpcfg_q;
  logic [7:0]      pin_a_q, pin_b_q;
  logic            glob_en;
  logic            wr_hpcfg;
  logic [15:0]     pin_fn;

  assign wr_hpcfg = bus_wr && (bus_addr == A_HPCFG);
  assign raw_clr  = (bus_wr && bus_addr == A_RAW)  ? bus_wdata : '0;
  assign stat_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      hpcfg_q <= '0;
      pin_a_q <= '0;
      pin_b_q <= '0;
      glob_en <= 1'b0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_MASK:  mask_q  <= bus_wdata;
        A_HPCFG: hpcfg_q <= bus_wdata[1:0];
        A_PINA:  pin_a_q <= bus_wdata;
        A_PINB:  pin_b_q <= bus_wdata;
        A_CTRL:  glob_en <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  irqc_events u_events (
    .clk(clk), .rst(rst), .src_lock(src_lock), .dyn_over(dyn_over),
    .pll_lock(pll_lock), .jack_pin(jack_pin), .fault_flags(fault_flags),
    .cfg_wr(wr_hpcfg), .ev(ev)
  );

  irqc_sticky u_raw (
    .clk(clk), .rst(rst), .set(ev), .clr(raw_clr), .q(raw_q)
  );

  irqc_sticky u_stat (
    .clk(clk), .rst(rst), .set(ev & mask_q), .clr(stat_clr), .q(stat_q)
  );

  assign irq_req = glob_en && (stat_q != '0);

  assign pin_fn = {pin_b_q, pin_a_q};
  for (genvar p = 0; p < 4; p++) begin : g_pin
    assign gpio_out[p] = irq_req && (pin_fn[4*p +: 4] == PIN_FN_IRQ);
  end

  always_comb begin
    unique case (bus_addr)
      A_HPCFG: bus_rdata = {6'd0, hpcfg_q};
      A_PINA:  bus_rdata = pin_a_q;
      A_PINB:  bus_rdata = pin_b_q;
      A_MASK:  bus_rdata = mask_q;
      A_RAW:   bus_rdata = raw_q;
      A_STAT:  bus_rdata = stat_q;
      A_CTRL:  bus_rdata = {7'd0, glob_en};
      default: bus_rdata = '0;
    endcase
  end

  // Masked status rises only on enabled sources
  assert_mask_gates_status_R2: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

  // Request never without global enable
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    !glob_en |-> !irq_req);

  // Routed pins only ever carry the request
  assert_pin_follows_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (gpio_out != 4'd0) |-> irq_req);
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic       clk = 0, rst = 1;
  logic [2:0] src_lock = 3'b111;
  logic       dyn_over = 0, pll_lock = 1, jack_pin = 0;
  logic [3:0] fault_flags = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic       irq_req;
  logic [3:0] gpio_out;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irqc_top uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic string req_of(input int i);
    if (i < 3) return "R5";
    if (i < 5) return "R6";
    if (i == 5) return "R8";
    if (i == 6) return "R7";
    return "R9";
  endfunction

  task automatic fire(input int i, input int k);
    @(negedge clk);
    case (i)
      0, 1, 2: src_lock[i] = 0;
      3: dyn_over = 1;
      4: pll_lock = 0;
      5: wr(8'h36, 8'h01);
      6: jack_pin = ~jack_pin;
      default: fault_flags[k] = 1;
    endcase
  endtask

  task automatic unfire(input int i, input int k);
    @(negedge clk);
    case (i)
      0, 1, 2: src_lock[i] = 1;
      3: dyn_over = 0;
      4: pll_lock = 1;
      5: ;
      6: jack_pin = ~jack_pin;
      default: fault_flags[k] = 0;
    endcase
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    settle();
    // R1 reset state
    foreach (uut.bus_rdata[b]) ; // no-op keeps loop form simple
    for (int a = 0; a < 7; a++) begin
      logic [7:0] addr;
      addr = (a == 0) ? 8'h36 : 8'hE2 + a[7:0];
      rd(addr, v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 irq", {7'd0, irq_req}, 8'h00);
    chk("R1 gpio", {4'd0, gpio_out}, 8'h00);

    wr(8'hE3, 8'h11);
    wr(8'hE8, 8'h01);

    // Sweep every source with its enable off and on
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] bitv;
        bitv = 8'h01 << i;
        wr(8'hE5, m ? bitv : 8'h00);
        wr(8'hE6, 8'hFF);
        wr(8'hE7, 8'hFF);
        fire(i, m);
        settle();
        rd(8'hE6, v); chk({"R4 raw ", req_of(i)}, v, bitv);
        rd(8'hE7, v); chk({"R2 masked ", req_of(i)}, v, m ? bitv : 8'h00);
        chk("R10 irq", {7'd0, irq_req}, {7'd0, m[0]});
        chk("R11 gpio", {4'd0, gpio_out}, m ? 8'h03 : 8'h00);
        wr(8'hE6, 8'hFF);
        unfire(i, m);
        settle();
        rd(8'hE6, v);
        chk({"restore edge ", req_of(i)}, v, (i == 6 || i == 5) ? ((i == 6) ? bitv : 8'h00) : 8'h00);
      end
    end

    // R9 each fault flag alone
    wr(8'hE5, 8'h80);
    for (int k = 0; k < 4; k++) begin
      wr(8'hE7, 8'hFF);
      fire(7, k);
      settle();
      rd(8'hE7, v); chk("R9 fault", v, 8'h80);
      unfire(7, k);
      settle();
    end

    // R8 readback
    wr(8'h36, 8'hFE);
    rd(8'h36, v); chk("R8 readback", v, 8'h02);

    // R3 sticky and write-1-to-clear
    wr(8'hE5, 8'hFF);
    wr(8'hE7, 8'hFF);
    fire(6, 0);
    settle();
    wr(8'hE5, 8'h00);
    wr(8'hE7, 8'hBF);
    rd(8'hE7, v); chk("R3 hold", v, 8'h40);
    // R10 global enable
    wr(8'hE8, 8'h00);
    chk("R10 disabled", {7'd0, irq_req}, 8'h00);
    chk("R10 gpio", {4'd0, gpio_out}, 8'h00);
    wr(8'hE8, 8'h01);
    chk("R10 enabled", {7'd0, irq_req}, 8'h01);

    // R11 pin function sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [3:0] code;
        logic [15:0] fn;
        code = (c == 3) ? 4'hF : c[3:0];
        fn = 16'(code) << (4 * p);
        wr(8'hE3, fn[7:0]);
        wr(8'hE4, fn[15:8]);
        chk("R11 route", {4'd0, gpio_out}, (code == 4'h1) ? (8'h01 << p) : 8'h00);
      end
    end

    wr(8'hE7, 8'h40);
    rd(8'hE7, v); chk("R3 clear", v, 8'h00);

    // R12 event and clear in the same cycle
    wr(8'hE5, 8'h40);
    fire(6, 0);
    settle();
    rd(8'hE7, v); chk("R12 preset", v, 8'h40);
    @(negedge clk);
    jack_pin = ~jack_pin;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'hE7; bus_wdata = 8'h40;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
    rd(8'hE7, v); chk("R12 event wins", v, 8'h40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule